// File: doc/BRIEF.md
# Per-VLAN Spanning Tree Ingress Gate

This block sits on the ingress side of one switch port. It keeps a 2-bit spanning-tree state for each of the 4096 VLAN IDs and a learning mode for the port. For every arriving frame it looks up the state of the frame's VID. It then gives a registered verdict: whether the frame may be forwarded, whether its source MAC may be learned, and whether the frame breaks port security.

A configuration side writes the state table. One request carries a start VID, a count and a state code. The block then walks consecutive VIDs and updates one entry per cycle, wrapping past the top VID. A state code of zero walks the range and changes nothing. A registered read port returns any entry, and a separate write sets the learning mode. In secure mode the port never learns. A frame whose source MAC the forwarding database already binds to another port is marked bad. It is then either dropped or, when the trap enable is set, handed to software.

Top module: `vlan_stp_gate`

## Requirements
- R1: After reset every VID reads state code 1 (discarding), the learn mode reads 0, cfg_busy is 0 and all decision outputs are 0.
- R2: A frame whose VID is in state 1 (discarding) gets dec_fwd=0 and dec_learn=0.
- R3: A frame whose VID is in state 2 (learning), with learn mode 2, gets dec_learn=1 and dec_fwd=0.
- R4: Writing state code 0 leaves every addressed entry unchanged.
- R5: A frame whose VID is in state 3 (forwarding), with learn mode 2, gets dec_fwd=1 and dec_learn=1. All decision outputs appear in the cycle after the frm_valid cycle, together with dec_valid=1.
- R6: An accepted write request with start VID S and count N (1..4096; larger values act as 4096) sets entries S, S+1, ... S+N-1 (modulo 4096), one per cycle. cfg_busy is 1 for exactly N cycles, starting the cycle after the request. No other entry changes.
- R7: A write request made while cfg_busy is 1, or with count 0, is ignored.
- R8: Learn mode 0 (off) and learn mode 1 (reserved) never learn, and forwarding still follows the VID state.
- R9: In learn mode 3 (secure), a frame whose source MAC is absent, or bound to this port (parameter LOCAL_PORT), is never learned and is forwarded according to its VID state.
- R10: In learn mode 3, a frame with frm_sa_hit=1 and frm_sa_port different from LOCAL_PORT gets dec_fwd=0 and dec_learn=0. With cfg_trap_en=0 it also gets dec_sec_drop=1, whatever its VID state.
- R11: The same violating frame with cfg_trap_en=1 gets dec_sec_trap=1 and dec_sec_drop=0. The two flags are never both 1.
- R12: cfg_rd_state shows the entry of cfg_rd_vid one cycle after cfg_rd_vid is applied. cfg_mode_rd shows the value from a cfg_mode_wr in the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_valid | input | 1 | State write request |
| cfg_wr_vid | input | 12 | First VID to write |
| cfg_wr_count | input | 13 | Number of consecutive VIDs |
| cfg_wr_state | input | 2 | State code to write (0 = keep) |
| cfg_busy | output | 1 | A write walk is in progress |
| cfg_rd_vid | input | 12 | VID to read back |
| cfg_rd_state | output | 2 | Registered state of cfg_rd_vid |
| cfg_mode_wr | input | 1 | Learn mode write strobe |
| cfg_mode_val | input | 2 | Learn mode to write |
| cfg_mode_rd | output | 2 | Current learn mode |
| cfg_trap_en | input | 1 | Send security violations to software |
| frm_valid | input | 1 | Frame descriptor valid |
| frm_vid | input | 12 | Frame VID |
| frm_sa_hit | input | 1 | Source MAC found in the forwarding database |
| frm_sa_port | input | 8 | Port bound to that source MAC |
| dec_valid | output | 1 | Decision valid |
| dec_fwd | output | 1 | Frame may be forwarded |
| dec_learn | output | 1 | Source MAC may be learned |
| dec_sec_drop | output | 1 | Security violation, drop |
| dec_sec_trap | output | 1 | Security violation, send to software |

## Verification
Some properties hold on every cycle, and the assertions check those. The table never holds or receives code 0. The write walk starts at the requested VID and advances by one each cycle. A forward verdict only follows a forwarding-state lookup, and a learn verdict only follows learn mode 2. The two security flags are exclusive and rule out forwarding and learning. Other behaviour can only be shown by the bench's scenarios: the reset contents of the whole table, wrap past VID 4095, clamping of oversized counts, requests ignored while busy, and the choice between drop and trap.

// File: rtl/stpg_pkg.sv
package stpg_pkg;

  typedef enum logic [1:0] {
    STP_KEEP    = 2'd0,
    STP_DISCARD = 2'd1,
    STP_LEARN   = 2'd2,
    STP_FORWARD = 2'd3
  } stp_code_e;

  typedef enum logic [1:0] {
    LM_OFF    = 2'd0,
    LM_RSVD   = 2'd1,
    LM_ON     = 2'd2,
    LM_SECURE = 2'd3
  } learn_mode_e;

  function automatic logic stp_may_forward(input logic [1:0] st);
    return st == STP_FORWARD;
  endfunction

  function automatic logic stp_may_learn(input logic [1:0] st);
    return (st == STP_LEARN) || (st == STP_FORWARD);
  endfunction

  function automatic logic mode_learns(input logic [1:0] m);
    return m == LM_ON;
  endfunction

  function automatic int unsigned clamp_len(input int unsigned req, input int unsigned limit);
    return (req > limit) ? limit : req;
  endfunction

endpackage

// File: rtl/stpg_state_table.sv
module stpg_state_table #(
  parameter int VID_W   = 12,
  parameter int SLOTS_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VID_W-1:0] wr_vid,
  input  logic [1:0]       wr_code,
  input  logic [VID_W-1:0] lk_vid,
  output logic [1:0]       lk_state,
  input  logic [VID_W-1:0] rd_vid,
  output logic [1:0]       rd_state
);
  import stpg_pkg::*;

  localparam int ENTRIES = 1 << VID_W;
  localparam int SLOTS   = 1 << SLOTS_W;
  localparam int WORDS   = ENTRIES / SLOTS;
  localparam int WORD_W  = 2 * SLOTS;
  localparam int IDX_W   = VID_W - SLOTS_W;

  logic [2*ENTRIES-1:0] flat;
  logic [IDX_W-1:0]     wr_word;
  logic [SLOTS_W-1:0]   wr_slot;

  assign wr_word = wr_vid[VID_W-1:SLOTS_W];
  assign wr_slot = wr_vid[SLOTS_W-1:0];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word_q;
    logic              hit_w;
    assign hit_w = wr_en && (wr_word == IDX_W'(w));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= {SLOTS{STP_DISCARD}};
      end else if (hit_w) begin
        word_q[{wr_slot, 1'b0} +: 2] <= wr_code;
      end
    end
    assign flat[w*WORD_W +: WORD_W] = word_q;
  end

  assign lk_state = flat[{lk_vid, 1'b0} +: 2];

  always_ff @(posedge clk) begin
    if (!rst_n) rd_state <= STP_DISCARD;
    else        rd_state <= flat[{rd_vid, 1'b0} +: 2];
  end

  // R4
  keep_code_never_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wr_code != STP_KEEP);

  // R4
  lookup_never_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_state != STP_KEEP);

endmodule

// File: rtl/stpg_bulk_writer.sv
module stpg_bulk_writer #(
  parameter int VID_W   = 12,
  parameter int COUNT_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VID_W-1:0]   req_vid,
  input  logic [COUNT_W-1:0] req_count,
  input  logic [1:0]         req_code,
  output logic               busy,
  output logic               wr_en,
  output logic [VID_W-1:0]   wr_vid,
  output logic [1:0]         wr_code
);
  import stpg_pkg::*;

  localparam int unsigned ENTRIES = 1 << VID_W;

  logic               busy_q;
  logic [VID_W-1:0]   cur_q;
  logic [COUNT_W-1:0] left_q;
  logic [1:0]         code_q;
  logic [COUNT_W-1:0] req_len;
  logic               accept_w;
  logic               step_last_w;

  assign req_len     = COUNT_W'(clamp_len(32'(req_count), ENTRIES));
  assign accept_w    = req_valid && !busy_q && (req_count != '0);
  assign step_last_w = busy_q && (left_q == COUNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      left_q <= '0;
      code_q <= STP_KEEP;
    end else if (accept_w) begin
      busy_q <= 1'b1;
      cur_q  <= req_vid;
      left_q <= req_len;
      code_q <= req_code;
    end else if (busy_q) begin
      cur_q  <= cur_q + 1'b1;
      left_q <= left_q - 1'b1;
      if (step_last_w) busy_q <= 1'b0;
    end
  end

  assign busy    = busy_q;
  assign wr_en   = busy_q && (code_q != STP_KEEP);
  assign wr_vid  = cur_q;
  assign wr_code = code_q;

  // R6
  walk_starts_at_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (busy && wr_vid == $past(req_vid)));

  // R6
  walk_consecutive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !step_last_w) |=> (busy && wr_vid == VID_W'($past(wr_vid) + 1'b1)));

  // R7
  code_held_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(code_q));

endmodule

// File: rtl/stpg_decide.sv
module stpg_decide #(
  parameter int          PORT_W     = 8,
  parameter int unsigned LOCAL_PORT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  input  logic [1:0]        stp_state,
  input  logic              sa_hit,
  input  logic [PORT_W-1:0] sa_port,
  input  logic [1:0]        mode,
  input  logic              trap_en,
  output logic              dec_valid,
  output logic              dec_fwd,
  output logic              dec_learn,
  output logic              dec_sec_drop,
  output logic              dec_sec_trap
);
  import stpg_pkg::*;

  logic viol_w;
  logic fwd_ok_w;
  logic learn_ok_w;

  assign viol_w     = (mode == LM_SECURE) && sa_hit && (sa_port != PORT_W'(LOCAL_PORT));
  assign fwd_ok_w   = stp_may_forward(stp_state) && !viol_w;
  assign learn_ok_w = stp_may_learn(stp_state) && mode_learns(mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid    <= 1'b0;
      dec_fwd      <= 1'b0;
      dec_learn    <= 1'b0;
      dec_sec_drop <= 1'b0;
      dec_sec_trap <= 1'b0;
    end else begin
      dec_valid    <= frm_valid;
      dec_fwd      <= frm_valid && fwd_ok_w;
      dec_learn    <= frm_valid && learn_ok_w;
      dec_sec_drop <= frm_valid && viol_w && !trap_en;
      dec_sec_trap <= frm_valid && viol_w && trap_en;
    end
  end

  // R5
  fwd_needs_forward_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fwd |-> ($past(stp_state) == STP_FORWARD && $past(frm_valid)));

  // R8
  learn_needs_mode_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_learn |-> ($past(mode) == LM_ON && $past(stp_state) != STP_DISCARD));

  // R11
  sec_flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec_sec_drop, dec_sec_trap}));

  // R10
  violation_blocks_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_sec_drop || dec_sec_trap) |-> (!dec_fwd && !dec_learn));

endmodule

// File: rtl/vlan_stp_gate.sv
module vlan_stp_gate #(
  parameter int          VID_W      = 12,
  parameter int          SLOTS_W    = 4,
  parameter int          PORT_W     = 8,
  parameter int unsigned LOCAL_PORT = 5,
  localparam int         COUNT_W    = VID_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_valid,
  input  logic [VID_W-1:0]   cfg_wr_vid,
  input  logic [COUNT_W-1:0] cfg_wr_count,
  input  logic [1:0]         cfg_wr_state,
  output logic               cfg_busy,
  input  logic [VID_W-1:0]   cfg_rd_vid,
  output logic [1:0]         cfg_rd_state,
  input  logic               cfg_mode_wr,
  input  logic [1:0]         cfg_mode_val,
  output logic [1:0]         cfg_mode_rd,
  input  logic               cfg_trap_en,
  input  logic               frm_valid,
  input  logic [VID_W-1:0]   frm_vid,
  input  logic               frm_sa_hit,
  input  logic [PORT_W-1:0]  frm_sa_port,
  output logic               dec_valid,
  output logic               dec_fwd,
  output logic               dec_learn,
  output logic               dec_sec_drop,
  output logic               dec_sec_trap
);
  import stpg_pkg::*;

  logic             tw_en;
  logic [VID_W-1:0] tw_vid;
  logic [1:0]       tw_code;
  logic [1:0]       lk_state;
  logic [1:0]       mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           mode_q <= LM_OFF;
    else if (cfg_mode_wr) mode_q <= cfg_mode_val;
  end
  assign cfg_mode_rd = mode_q;

  stpg_bulk_writer #(.VID_W(VID_W), .COUNT_W(COUNT_W)) u_writer (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (cfg_wr_valid),
    .req_vid   (cfg_wr_vid),
    .req_count (cfg_wr_count),
    .req_code  (cfg_wr_state),
    .busy      (cfg_busy),
    .wr_en     (tw_en),
    .wr_vid    (tw_vid),
    .wr_code   (tw_code)
  );

  stpg_state_table #(.VID_W(VID_W), .SLOTS_W(SLOTS_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (tw_en),
    .wr_vid   (tw_vid),
    .wr_code  (tw_code),
    .lk_vid   (frm_vid),
    .lk_state (lk_state),
    .rd_vid   (cfg_rd_vid),
    .rd_state (cfg_rd_state)
  );

  stpg_decide #(.PORT_W(PORT_W), .LOCAL_PORT(LOCAL_PORT)) u_decide (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_valid    (frm_valid),
    .stp_state    (lk_state),
    .sa_hit       (frm_sa_hit),
    .sa_port      (frm_sa_port),
    .mode         (mode_q),
    .trap_en      (cfg_trap_en),
    .dec_valid    (dec_valid),
    .dec_fwd      (dec_fwd),
    .dec_learn    (dec_learn),
    .dec_sec_drop (dec_sec_drop),
    .dec_sec_trap (dec_sec_trap)
  );

  // R12
  mode_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_mode_wr) |-> cfg_mode_rd == $past(cfg_mode_val));

endmodule

// File: tb/vlan_stp_gate_bench.sv
`timescale 1ns/1ps
module vlan_stp_gate_bench;

  localparam int NV    = 4096;
  localparam int LOCAL = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_valid = 1'b0;
  logic [11:0] cfg_wr_vid = '0;
  logic [12:0] cfg_wr_count = '0;
  logic [1:0]  cfg_wr_state = '0;
  logic        cfg_busy;
  logic [11:0] cfg_rd_vid = '0;
  logic [1:0]  cfg_rd_state;
  logic        cfg_mode_wr = 1'b0;
  logic [1:0]  cfg_mode_val = '0;
  logic [1:0]  cfg_mode_rd;
  logic        cfg_trap_en = 1'b0;
  logic        frm_valid = 1'b0;
  logic [11:0] frm_vid = '0;
  logic        frm_sa_hit = 1'b0;
  logic [7:0]  frm_sa_port = '0;
  logic        dec_valid, dec_fwd, dec_learn, dec_sec_drop, dec_sec_trap;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  logic [1:0] exp_st [NV];
  logic [1:0] cur_mode = 2'd0;

  always #10 clk = ~clk;

  vlan_stp_gate #(.LOCAL_PORT(LOCAL)) u_vlan_stp_gate (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr_valid(cfg_wr_valid), .cfg_wr_vid(cfg_wr_vid), .cfg_wr_count(cfg_wr_count),
    .cfg_wr_state(cfg_wr_state), .cfg_busy(cfg_busy),
    .cfg_rd_vid(cfg_rd_vid), .cfg_rd_state(cfg_rd_state),
    .cfg_mode_wr(cfg_mode_wr), .cfg_mode_val(cfg_mode_val), .cfg_mode_rd(cfg_mode_rd),
    .cfg_trap_en(cfg_trap_en),
    .frm_valid(frm_valid), .frm_vid(frm_vid), .frm_sa_hit(frm_sa_hit), .frm_sa_port(frm_sa_port),
    .dec_valid(dec_valid), .dec_fwd(dec_fwd), .dec_learn(dec_learn),
    .dec_sec_drop(dec_sec_drop), .dec_sec_trap(dec_sec_trap)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // model: entry update from a walk request
  task automatic model_apply(input logic [11:0] vid, input logic [12:0] cnt, input logic [1:0] code);
    int n;
    n = (int'(cnt) > NV) ? NV : int'(cnt);
    if (code != 2'd0)
      for (int i = 0; i < n; i++) exp_st[(int'(vid) + i) % NV] = code;
  endtask

  task automatic bulk(input logic [11:0] vid, input logic [12:0] cnt, input logic [1:0] code,
                      output int cyc);
    @(negedge clk);
    cfg_wr_valid = 1'b1; cfg_wr_vid = vid; cfg_wr_count = cnt; cfg_wr_state = code;
    @(negedge clk);
    cfg_wr_valid = 1'b0;
    cyc = 0;
    while (cfg_busy) begin cyc++; @(negedge clk); end
    model_apply(vid, cnt, code);
  endtask

  task automatic rd(input logic [11:0] vid, output logic [1:0] val);
    @(negedge clk);
    cfg_rd_vid = vid;
    @(negedge clk);
    val = cfg_rd_state;
  endtask

  task automatic sweep(input string tag);
    int bad_cnt = 0;
    logic [1:0] v;
    for (int i = 0; i < NV; i++) begin
      rd(12'(i), v);
      if (v !== exp_st[i]) bad_cnt++;
    end
    chk(tag, 32'(bad_cnt), 32'd0);
  endtask

  task automatic set_mode(input string tag, input logic [1:0] m);
    @(negedge clk);
    cfg_mode_wr = 1'b1; cfg_mode_val = m;
    @(negedge clk);
    cfg_mode_wr = 1'b0;
    cur_mode = m;
    chk(tag, 32'(cfg_mode_rd), 32'(m));
  endtask

  task automatic frame_chk(input string tag, input logic [11:0] vid, input logic hit,
                           input logic [7:0] port);
    logic [1:0] st;
    logic bad, f, l, d, t;
    st  = exp_st[vid];
    bad = (cur_mode == 2'd3) & hit & (port != 8'(LOCAL));
    f   = (st == 2'd3) & ~bad;
    l   = (cur_mode == 2'd2) & st[1];
    d   = bad & ~cfg_trap_en;
    t   = bad & cfg_trap_en;
    @(negedge clk);
    frm_valid = 1'b1; frm_vid = vid; frm_sa_hit = hit; frm_sa_port = port;
    @(negedge clk);
    frm_valid = 1'b0;
    chk(tag, {27'd0, dec_valid, dec_fwd, dec_learn, dec_sec_drop, dec_sec_trap},
             {27'd0, 1'b1, f, l, d, t});
  endtask

  task automatic t_reset();
    logic [1:0] v;
    chk("R1 outputs after reset", {26'd0, cfg_busy, dec_valid, dec_fwd, dec_learn, dec_sec_drop, dec_sec_trap}, 32'd0);
    chk("R1 mode after reset", 32'(cfg_mode_rd), 32'd0);
    rd(12'd0, v);    chk("R1 vid 0 discarding", 32'(v), 32'd1);
    rd(12'd4095, v); chk("R1 vid 4095 discarding", 32'(v), 32'd1);
    sweep("R1 whole table discarding");
  endtask

  task automatic t_states();
    int cyc;
    logic [1:0] v;
    set_mode("R12 mode write 2", 2'd2);
    frame_chk("R2 discarding frame", 12'd100, 1'b0, 8'd0);
    bulk(12'd7, 13'd1, 2'd3, cyc);
    rd(12'd7, v); chk("R12 readback vid 7", 32'(v), 32'd3);
    frame_chk("R5 forwarding frame", 12'd7, 1'b0, 8'd0);
    bulk(12'd8, 13'd1, 2'd2, cyc);
    frame_chk("R3 learning frame", 12'd8, 1'b1, 8'd5);
  endtask

  task automatic t_keep();
    int cyc;
    logic [1:0] v;
    bulk(12'd7, 13'd1, 2'd0, cyc);
    rd(12'd7, v); chk("R4 keep single vid 7", 32'(v), 32'd3);
    bulk(12'd6, 13'd4, 2'd0, cyc);
    chk("R4 keep walk length", 32'(cyc), 32'd4);
    rd(12'd8, v); chk("R4 keep walk vid 8", 32'(v), 32'd2);
  endtask

  task automatic t_wrap();
    int cyc;
    bulk(12'd4094, 13'd4, 2'd3, cyc);
    chk("R6 busy cycles wrap walk", 32'(cyc), 32'd4);
    sweep("R6 table after wrap walk");
  endtask

  task automatic t_ignore();
    int cyc;
    logic [1:0] v;
    @(negedge clk);
    cfg_wr_valid = 1'b1; cfg_wr_vid = 12'd200; cfg_wr_count = 13'd20; cfg_wr_state = 2'd3;
    @(negedge clk);
    cfg_wr_vid = 12'd300; cfg_wr_count = 13'd1; cfg_wr_state = 2'd1;
    @(negedge clk);
    cfg_wr_valid = 1'b0;
    while (cfg_busy) @(negedge clk);
    model_apply(12'd200, 13'd20, 2'd3);
    rd(12'd300, v); chk("R7 request while busy ignored", 32'(v), 32'(exp_st[300]));
    rd(12'd219, v); chk("R6 last entry of walk", 32'(v), 32'd3);
    rd(12'd220, v); chk("R6 entry past walk untouched", 32'(v), 32'(exp_st[220]));
    bulk(12'd50, 13'd0, 2'd3, cyc);
    chk("R7 count zero no busy", 32'(cyc), 32'd0);
    rd(12'd50, v); chk("R7 count zero no write", 32'(v), 32'(exp_st[50]));
  endtask

  task automatic t_modes();
    int cyc;
    bulk(12'd400, 13'd1, 2'd3, cyc);
    set_mode("R12 mode write 0", 2'd0);
    frame_chk("R8 mode 0 no learn", 12'd400, 1'b0, 8'd0);
    set_mode("R12 mode write 1", 2'd1);
    frame_chk("R8 mode 1 reserved no learn", 12'd400, 1'b0, 8'd0);
    set_mode("R12 mode write 2 again", 2'd2);
    frame_chk("R5 mode 2 learns again", 12'd400, 1'b0, 8'd0);
  endtask

  task automatic t_secure();
    int cyc;
    bulk(12'd401, 13'd1, 2'd1, cyc);
    set_mode("R12 mode write 3", 2'd3);
    frame_chk("R10 hit other port drop", 12'd400, 1'b1, 8'd9);
    frame_chk("R9 hit local port forwards", 12'd400, 1'b1, 8'(LOCAL));
    frame_chk("R9 miss forwards no learn", 12'd400, 1'b0, 8'd9);
    frame_chk("R10 drop in discarding state", 12'd401, 1'b1, 8'd9);
    @(negedge clk); cfg_trap_en = 1'b1;
    frame_chk("R11 trap instead of drop", 12'd400, 1'b1, 8'd9);
    @(negedge clk); cfg_trap_en = 1'b0;
    set_mode("R12 mode back to 2", 2'd2);
  endtask

  task automatic t_clamp();
    int cyc;
    bulk(12'd10, 13'd5000, 2'd2, cyc);
    chk("R6 oversize count clamps", 32'(cyc), 32'd4096);
    sweep("R6 table after clamped walk");
    frame_chk("R3 learning after clamp", 12'd9, 1'b0, 8'd0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NV; i++) exp_st[i] = 2'd1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_states();
    t_keep();
    t_wrap();
    t_ignore();
    t_modes();
    t_secure();
    t_clamp();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule